// File: doc/BRIEF.md
# Stage-Skipping In-Order Pipeline Sequencer

This block is the control half of a six-stage in-order pipeline made of fetch, decode and four execution sub-stages (E1 to E4). The four sub-stages were formed by splitting one long execute step into four. An instruction needs only some of them. While it sits in decode, its opcode class is turned into a four-bit flow mask, one bit per sub-stage. The sequencer then steps the instruction through the marked sub-stages only and passes over the rest. A short instruction therefore leaves after three cycles, and the longest takes six.

The datapath watches the per-stage valid and enable outputs to know which stage holds work and when that work moves on. Instructions are tracked by an opaque tag supplied with each fetch and returned on the retire strobe. Retirement follows program order. An instruction never jumps over an occupied sub-stage.

A decoded instruction may be unable to reach its first sub-stage because an older one is in the way. It then drops into a single side buffer, which frees decode for the next instruction. If the buffer is already occupied, decode and fetch hold. A global stall input freezes everything.

Top module: `flowpipe_seq`

## Requirements
- R1: After reset, all six stage-valid bits and the buffer-valid output are 0, the retire strobe is 0, and the fetch-ready output is 1.
- R2: The flow mask for class c is bits [4c+3:4c] of parameter FLOW_TABLE, and mask bit j selects sub-stage E(j+1). The default table gives class 0..7 the masks 0001, 0010, 0100, 1000, 0011, 0101, 1010 and 1111 (written E4..E1).
- R3: In an otherwise empty pipe, an instruction accepted at clock edge e retires at edge e+2+popcount(mask). The retire strobe and its tag are presented during the cycle before that edge. This gives 3 cycles for a single-bit mask and 6 for a full mask.
- R4: stage_valid_o bit 0 is fetch, bit 1 is decode, and bits 2..5 are E1..E4. A lone instruction occupies fetch, then decode, then each marked sub-stage in ascending order, one cycle each, and no other stage.
- R5: Every accepted instruction retires exactly once. Retirement is in acceptance order, at most one per cycle.
- R6: When the buffer is empty and a decoded instruction cannot enter its first sub-stage (an older instruction occupies a sub-stage below or at that target and does not leave), it moves into the buffer, and buffer-valid rises.
- R7: When the buffer is occupied and cannot issue, decode holds its instruction. fetch_ready then falls once fetch is also full, and no instruction is lost.
- R8: While stall is high, no stage-valid or buffer-valid bit changes, the retire strobe is 0 and fetch_ready is 0.
- R9: A stage's enable bit is high exactly in a cycle in which its instruction leaves that stage, and never for an empty stage.
- R10: An instruction offered while fetch_ready is high is accepted at that edge and occupies fetch in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze all stages and the buffer |
| in_valid_i | input | 1 | An instruction is offered to fetch |
| in_class_i | input | CLASS_W | Opcode class of the offered instruction |
| in_tag_i | input | TAG_W | Tag carried with the offered instruction |
| in_ready_o | output | 1 | Fetch accepts the offered instruction at this edge |
| stage_valid_o | output | 6 | Occupancy: fetch, decode, E1..E4 from bit 0 |
| stage_enable_o | output | 6 | Stage's instruction advances this cycle |
| buf_valid_o | output | 1 | Side buffer holds an instruction |
| retire_o | output | 1 | An instruction completes this cycle |
| retire_tag_o | output | TAG_W | Tag of the completing instruction |

## Verification
Each of the eight classes is first sent alone, so the cycle-by-cycle stage trace and the retire cycle show whether the mask lookup, the skipping of unmarked sub-stages and the three-to-six-cycle latency are right. A back-to-back mix of long and short classes follows. It separates correct in-order blocking from overtaking, because a short instruction behind a long one would retire early if allowed to jump. A long instruction followed by several E4-only ones fills the buffer and then holds fetch, which shows both the parking path and the back-pressure path. A stall held across a busy pipe shows the freeze, and the scoreboard then confirms that nothing was lost or doubled.

// File: rtl/flowpipe_pkg.sv
// Shared constants and helpers for the stage-skipping sequencer.
// Assumes the number of execution sub-stages is a power of two so that
// a position code of SEL_W+1 bits can name every sub-stage plus "retire".
package flowpipe_pkg;
    localparam int EXN   = 4;              // execution sub-stages
    localparam int SEL_W = $clog2(EXN);    // bits to index one sub-stage
    localparam int POS_W = SEL_W + 1;      // sub-stage index or retire code
    localparam int NSTG  = EXN + 2;        // fetch + decode + sub-stages

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [EXN-1:0]   flow_t;

    localparam pos_t RETIRE_POS = pos_t'(EXN);

    // Lowest marked sub-stage at or above 'from'; RETIRE_POS if none.
    function automatic pos_t pick_next(input flow_t m, input pos_t from);
        pos_t r;
        r = RETIRE_POS;
        for (int i = EXN - 1; i >= 0; i--) begin
            if (m[i] && (pos_t'(i) >= from)) r = pos_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/flowpipe_decode.sv
// Class-to-flow-mask lookup used by the decode stage.
// Assumes every table entry is non-zero; an all-zero entry would be
// routed to E1 by the issue logic and retire from there.
module flowpipe_decode
    import flowpipe_pkg::*;
#(
    parameter int CLASS_W = 3,
    parameter logic [(1 << CLASS_W) * EXN - 1:0] FLOW_TABLE = 32'hFA53_8421
) (
    input  logic [CLASS_W-1:0] class_i,
    output flow_t              mask_o
);
    // Select the nibble belonging to the class.
    always_comb begin
        mask_o = FLOW_TABLE[class_i * EXN +: EXN];
    end
endmodule

// File: rtl/flowpipe_front.sv
// Fetch and decode registers. Fetch takes a new instruction when it is
// empty or emptying; decode takes from fetch when decode is empty or its
// instruction is leaving (d_leave_i, already gated by stall).
module flowpipe_front
    import flowpipe_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int CLASS_W = 3,
    parameter logic [(1 << CLASS_W) * EXN - 1:0] FLOW_TABLE = 32'hFA53_8421
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic               in_valid_i,
    input  logic [CLASS_W-1:0] in_class_i,
    input  logic [TAG_W-1:0]   in_tag_i,
    output logic               in_ready_o,
    input  logic               d_leave_i,
    output logic               f_valid_o,
    output logic               f_leave_o,
    output logic               d_valid_o,
    output logic [TAG_W-1:0]   d_tag_o,
    output flow_t              d_mask_o
);
    logic               f_valid_q, d_valid_q;
    logic [TAG_W-1:0]   f_tag_q, d_tag_q;
    logic [CLASS_W-1:0] f_class_q, d_class_q;
    logic               f_take;

    // Handshake: fetch moves on when decode has room this cycle.
    always_comb begin
        f_leave_o  = f_valid_q && !stall_i && (!d_valid_q || d_leave_i);
        in_ready_o = !stall_i && (!f_valid_q || f_leave_o);
        f_take     = in_valid_i && in_ready_o;
    end

    // Occupancy flags of fetch and decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_valid_q <= 1'b0;
            d_valid_q <= 1'b0;
        end else begin
            if (f_take)         f_valid_q <= 1'b1;
            else if (f_leave_o) f_valid_q <= 1'b0;
            if (f_leave_o)      d_valid_q <= 1'b1;
            else if (d_leave_i) d_valid_q <= 1'b0;
        end
    end

    // Payload of fetch and decode; only meaningful while valid.
    always_ff @(posedge clk) begin
        if (f_take) begin
            f_tag_q   <= in_tag_i;
            f_class_q <= in_class_i;
        end
        if (f_leave_o) begin
            d_tag_q   <= f_tag_q;
            d_class_q <= f_class_q;
        end
    end

    flowpipe_decode #(
        .CLASS_W    (CLASS_W),
        .FLOW_TABLE (FLOW_TABLE)
    ) decode_i (
        .class_i (d_class_q),
        .mask_o  (d_mask_o)
    );

    // Expose decode contents.
    always_comb begin
        f_valid_o = f_valid_q;
        d_valid_o = d_valid_q;
        d_tag_o   = d_tag_q;
    end
endmodule

// File: rtl/flowpipe_issue.sv
// Issue point between decode and the sub-stages, with a one-entry side
// buffer. The buffer is older than decode, so while it is full only the
// buffer may issue and decode can at most move into it. Assumes entry_ok_i
// already carries the stall and in-order landing rules.
module flowpipe_issue
    import flowpipe_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic             d_valid_i,
    input  logic [TAG_W-1:0] d_tag_i,
    input  flow_t            d_mask_i,
    input  logic [EXN-1:0]   entry_ok_i,
    output logic             d_leave_o,
    output logic             ent_valid_o,
    output logic [TAG_W-1:0] ent_tag_o,
    output flow_t            ent_mask_o,
    output logic             buf_valid_o
);
    logic             b_valid_q;
    logic [TAG_W-1:0] b_tag_q;
    flow_t            b_mask_q;
    pos_t             b_tgt, d_tgt;
    logic             b_go, d_go, d_park;

    // Choose who issues and whether decode parks.
    always_comb begin
        b_tgt     = pick_next(b_mask_q, '0);
        d_tgt     = pick_next(d_mask_i, '0);
        b_go      = b_valid_q && entry_ok_i[b_tgt[SEL_W-1:0]];
        d_go      = !b_valid_q && d_valid_i && entry_ok_i[d_tgt[SEL_W-1:0]];
        d_leave_o = !stall_i && d_valid_i && (b_valid_q ? b_go : 1'b1);
        d_park    = d_leave_o && !d_go;
        ent_valid_o = b_go || d_go;
        ent_tag_o   = b_valid_q ? b_tag_q  : d_tag_i;
        ent_mask_o  = b_valid_q ? b_mask_q : d_mask_i;
    end

    // Buffer occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)      b_valid_q <= 1'b0;
        else if (d_park) b_valid_q <= 1'b1;
        else if (b_go)   b_valid_q <= 1'b0;
    end

    // Buffer payload.
    always_ff @(posedge clk) begin
        if (d_park) begin
            b_tag_q  <= d_tag_i;
            b_mask_q <= d_mask_i;
        end
    end

    // Expose buffer state.
    always_comb buf_valid_o = b_valid_q;
endmodule

// File: rtl/flowpipe_exec.sv
// The four execution sub-stages. Each occupant moves to its next marked
// sub-stage, or retires, only if every sub-stage it would pass over is
// empty and its destination is empty or emptying this cycle. Decisions
// ripple from E4 downwards. This keeps program order and allows at most
// one retirement per cycle.
module flowpipe_exec
    import flowpipe_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    input  logic             ent_valid_i,
    input  logic [TAG_W-1:0] ent_tag_i,
    input  flow_t            ent_mask_i,
    output logic [EXN-1:0]   entry_ok_o,
    output logic [EXN-1:0]   valid_o,
    output logic [EXN-1:0]   leave_o,
    output logic             retire_o,
    output logic [TAG_W-1:0] retire_tag_o
);
    logic [EXN-1:0]   v_q, n_v, leave_c;
    logic [TAG_W-1:0] tag_q  [EXN];
    logic [TAG_W-1:0] n_tag  [EXN];
    flow_t            mask_q [EXN];
    flow_t            n_mask [EXN];
    pos_t             tgt_c  [EXN];
    pos_t             ent_tgt;

    // Per-slot destination and permission to leave, top slot first.
    always_comb begin : route
        logic [EXN-1:0] lv;
        lv = '0;
        for (int k = EXN - 1; k >= 0; k--) begin
            tgt_c[k] = pick_next(mask_q[k], pos_t'(k + 1));
            if (v_q[k] && !stall_i) begin
                lv[k] = 1'b1;
                for (int j = k + 1; j < EXN; j++) begin
                    if ((pos_t'(j) < tgt_c[k]) && v_q[j]) lv[k] = 1'b0;
                end
                if ((tgt_c[k] != RETIRE_POS) && v_q[tgt_c[k][SEL_W-1:0]]
                    && !lv[tgt_c[k][SEL_W-1:0]]) lv[k] = 1'b0;
            end
        end
        leave_c = lv;
    end

    // Where a newly issued instruction may land.
    always_comb begin : landing
        logic below;
        below = 1'b0;
        for (int t = 0; t < EXN; t++) begin
            entry_ok_o[t] = !stall_i && !below && (!v_q[t] || leave_c[t]);
            below         = below || v_q[t];
        end
    end

    // Retirement strobe and tag.
    always_comb begin
        retire_o     = 1'b0;
        retire_tag_o = '0;
        for (int k = 0; k < EXN; k++) begin
            if (leave_c[k] && (tgt_c[k] == RETIRE_POS)) begin
                retire_o     = 1'b1;
                retire_tag_o = tag_q[k];
            end
        end
    end

    // Next contents of every slot after moves and issue.
    always_comb begin : advance
        ent_tgt = pick_next(ent_mask_i, '0);
        for (int k = 0; k < EXN; k++) begin
            n_v[k]    = v_q[k] && !leave_c[k];
            n_tag[k]  = tag_q[k];
            n_mask[k] = mask_q[k];
        end
        for (int k = 0; k < EXN; k++) begin
            if (leave_c[k] && (tgt_c[k] != RETIRE_POS)) begin
                n_v[tgt_c[k][SEL_W-1:0]]    = 1'b1;
                n_tag[tgt_c[k][SEL_W-1:0]]  = tag_q[k];
                n_mask[tgt_c[k][SEL_W-1:0]] = mask_q[k];
            end
        end
        if (ent_valid_i) begin
            n_v[ent_tgt[SEL_W-1:0]]    = 1'b1;
            n_tag[ent_tgt[SEL_W-1:0]]  = ent_tag_i;
            n_mask[ent_tgt[SEL_W-1:0]] = ent_mask_i;
        end
    end

    // Slot occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= n_v;
    end

    // Slot payload.
    always_ff @(posedge clk) begin
        tag_q  <= n_tag;
        mask_q <= n_mask;
    end

    // Expose occupancy and movement.
    always_comb begin
        valid_o = v_q;
        leave_o = leave_c;
    end
endmodule

// File: rtl/flowpipe_seq.sv
// Top of the stage-skipping sequencer: fetch/decode front, issue point
// with side buffer, and the execution sub-stage chain. Produces per-stage
// valid and enable bits (fetch in bit 0, E4 in the top bit) and a retire
// strobe with the instruction's tag. Holds no datapath.
module flowpipe_seq
    import flowpipe_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int CLASS_W = 3,
    parameter logic [(1 << CLASS_W) * EXN - 1:0] FLOW_TABLE = 32'hFA53_8421
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic               in_valid_i,
    input  logic [CLASS_W-1:0] in_class_i,
    input  logic [TAG_W-1:0]   in_tag_i,
    output logic               in_ready_o,
    output logic [NSTG-1:0]    stage_valid_o,
    output logic [NSTG-1:0]    stage_enable_o,
    output logic               buf_valid_o,
    output logic               retire_o,
    output logic [TAG_W-1:0]   retire_tag_o
);
    logic             f_valid, f_leave, d_valid, d_leave, ent_valid;
    logic [TAG_W-1:0] d_tag, ent_tag;
    flow_t            d_mask, ent_mask;
    logic [EXN-1:0]   entry_ok, e_valid, e_leave;

    flowpipe_front #(
        .TAG_W (TAG_W), .CLASS_W (CLASS_W), .FLOW_TABLE (FLOW_TABLE)
    ) front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_i    (stall_i),
        .in_valid_i (in_valid_i),
        .in_class_i (in_class_i),
        .in_tag_i   (in_tag_i),
        .in_ready_o (in_ready_o),
        .d_leave_i  (d_leave),
        .f_valid_o  (f_valid),
        .f_leave_o  (f_leave),
        .d_valid_o  (d_valid),
        .d_tag_o    (d_tag),
        .d_mask_o   (d_mask)
    );

    flowpipe_issue #(.TAG_W (TAG_W)) issue_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall_i     (stall_i),
        .d_valid_i   (d_valid),
        .d_tag_i     (d_tag),
        .d_mask_i    (d_mask),
        .entry_ok_i  (entry_ok),
        .d_leave_o   (d_leave),
        .ent_valid_o (ent_valid),
        .ent_tag_o   (ent_tag),
        .ent_mask_o  (ent_mask),
        .buf_valid_o (buf_valid_o)
    );

    flowpipe_exec #(.TAG_W (TAG_W)) exec_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_i      (stall_i),
        .ent_valid_i  (ent_valid),
        .ent_tag_i    (ent_tag),
        .ent_mask_i   (ent_mask),
        .entry_ok_o   (entry_ok),
        .valid_o      (e_valid),
        .leave_o      (e_leave),
        .retire_o     (retire_o),
        .retire_tag_o (retire_tag_o)
    );

    // Assemble per-stage status vectors.
    always_comb begin
        stage_valid_o  = {e_valid, d_valid, f_valid};
        stage_enable_o = {e_leave, d_leave, f_leave};
    end
endmodule

// File: rtl/flowpipe_seq_chk.sv
// Protocol checks for flowpipe_seq, attached by bind below.
module flowpipe_seq_chk
    import flowpipe_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            stall_i,
    input logic            in_valid_i,
    input logic            in_ready_o,
    input logic [NSTG-1:0] stage_valid_o,
    input logic [NSTG-1:0] stage_enable_o,
    input logic            buf_valid_o,
    input logic            retire_o
);
    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(stage_valid_o) && $stable(buf_valid_o)));

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (!retire_o && !in_ready_o));

    // R9
    enable_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_enable_o & ~stage_valid_o) == '0);

    // R10
    fetch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> stage_valid_o[0]);

    // R5
    retire_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |-> ($countones(stage_valid_o[NSTG-1:2]) >= 1));

    // R7
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid_o && stage_valid_o[1] && !stage_enable_o[1] && stage_valid_o[0])
        |-> !in_ready_o);
endmodule

bind flowpipe_seq flowpipe_seq_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall_i        (stall_i),
    .in_valid_i     (in_valid_i),
    .in_ready_o     (in_ready_o),
    .stage_valid_o  (stage_valid_o),
    .stage_enable_o (stage_enable_o),
    .buf_valid_o    (buf_valid_o),
    .retire_o       (retire_o)
);

// File: tb/flowpipe_seq_tb_top.sv
`timescale 1ns/1ps
module flowpipe_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_class = '0;
    logic [7:0] in_tag = '0;
    logic       in_ready;
    logic [5:0] stage_valid, stage_enable;
    logic       buf_valid, retire;
    logic [7:0] retire_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_issue_cyc = 0;
    logic [7:0] next_tag = 8'd1;
    logic [7:0] exp_q[$];
    bit saw_buf = 0;
    bit saw_block = 0;
    bit done = 0;

    flowpipe_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall_i        (stall),
        .in_valid_i     (in_valid),
        .in_class_i     (in_class),
        .in_tag_i       (in_tag),
        .in_ready_o     (in_ready),
        .stage_valid_o  (stage_valid),
        .stage_enable_o (stage_enable),
        .buf_valid_o    (buf_valid),
        .retire_o       (retire),
        .retire_tag_o   (retire_tag)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL R5 watchdog: actual %0d expected below %0d", cyc, 20000);
            summary();
            $finish;
        end
    end

    // Scoreboard: every retirement must match the oldest outstanding tag.
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_valid) saw_buf = 1;
            if (in_valid && !in_ready && !stall) saw_block = 1;
            if (retire) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 retire with none outstanding", retire_tag, -1);
                end else begin
                    check(retire_tag == exp_q[0], "R5 retire order", retire_tag, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    function automatic logic [3:0] exp_mask(input int c);
        logic [31:0] tbl;
        tbl = 32'hFA53_8421;
        return tbl[4*c +: 4];
    endfunction

    // Offer one instruction and wait until it is taken (R10).
    task automatic issue(input logic [2:0] cls);
        in_valid = 1'b1;
        in_class = cls;
        in_tag   = next_tag;
        @(negedge clk);
        while (!in_ready) begin
            @(posedge clk); #1;
            @(negedge clk);
        end
        last_issue_cyc = cyc;
        exp_q.push_back(next_tag);
        next_tag = next_tag + 8'd1;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(stage_valid == 6'b0, "R1 stage valid", stage_valid, 0);
        check(buf_valid == 1'b0, "R1 buffer", buf_valid, 0);
        check(retire == 1'b0, "R1 retire", retire, 0);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        @(posedge clk); #1;
    endtask

    // Lone instruction: trace, latency, enables and visited sub-stages.
    task automatic t_isolated(input int cls);
        logic [3:0] m;
        logic [5:0] tr [1:6];
        logic [3:0] visited;
        int n, p;
        m = exp_mask(cls);
        n = 2 + $countones(m);
        tr[1] = 6'b000001;
        tr[2] = 6'b000010;
        p = 3;
        for (int j = 0; j < 4; j++) begin
            if (m[j]) begin
                tr[p] = 6'b000100 << j;
                p++;
            end
        end
        visited = '0;
        issue(3'(cls));
        for (int off = 1; off <= n; off++) begin
            @(negedge clk);
            check(stage_valid == tr[off], "R4 stage trace", stage_valid, tr[off]);
            check(stage_enable == stage_valid, "R9 enable", stage_enable, stage_valid);
            check(retire == (off == n), "R3 retire timing", retire, off == n);
            visited = visited | stage_valid[5:2];
            if (off == n)
                check(cyc - last_issue_cyc == n, "R3 latency", cyc - last_issue_cyc, n);
        end
        check(visited == m, "R2 flow mask", visited, m);
        @(negedge clk);
        check(stage_valid == 6'b0, "R4 empty after", stage_valid, 0);
        @(posedge clk); #1;
    endtask

    // Mixed back-to-back stream: order and completeness.
    task automatic t_mix();
        int seq [14] = '{7, 0, 3, 1, 5, 2, 6, 4, 7, 3, 0, 2, 1, 5};
        foreach (seq[i]) issue(3'(seq[i]));
        drain("R5 mixed stream complete");
    endtask

    // Long then E4-only instructions: buffer parks, then fetch holds.
    task automatic t_buffer();
        saw_buf = 0;
        saw_block = 0;
        issue(3'd7);
        for (int i = 0; i < 5; i++) issue(3'd3);
        drain("R7 buffered stream complete");
        check(saw_buf, "R6 buffer used", saw_buf, 1);
        check(saw_block, "R7 fetch held", saw_block, 1);
    endtask

    // Stall across a busy pipe.
    task automatic t_stall();
        logic [5:0] snap_v;
        logic       snap_b;
        issue(3'd7);
        issue(3'd3);
        issue(3'd5);
        stall    = 1'b1;
        in_valid = 1'b1;
        in_class = 3'd0;
        in_tag   = next_tag;
        @(negedge clk);
        snap_v = stage_valid;
        snap_b = buf_valid;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(stage_valid == snap_v, "R8 frozen stages", stage_valid, snap_v);
            check(buf_valid == snap_b, "R8 frozen buffer", buf_valid, snap_b);
            check(retire == 1'b0, "R8 no retire", retire, 0);
            check(in_ready == 1'b0, "R8 not ready", in_ready, 0);
        end
        @(posedge clk); #1;
        stall = 1'b0;
        issue(3'd0);
        drain("R8 stream complete after stall");
    endtask

    // Slow instruction followed by a fast one: fast must wait.
    task automatic t_order();
        issue(3'd7);
        issue(3'd0);
        issue(3'd3);
        drain("R5 no overtaking");
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 8; c++) t_isolated(c);
        t_order();
        t_mix();
        t_buffer();
        t_stall();
        repeat (4) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule